// File: doc/BRIEF.md
# Adaptive Peak Edge Detector

The detector receives one unsigned amplitude sample on every clock and marks the points where the signal turns at a high peak or at a low trough. It keeps a running maximum and a running minimum of the stream. Both drift one step toward the current sample at a fixed sample interval, so the detector follows slow changes in signal strength. From this envelope and a sensitivity threshold it works out two trigger levels. It also works out two re-arm levels that sit a quarter of the envelope span closer to the middle. The band between a trigger level and its re-arm level gives the detector its hysteresis.

There are two registered results. The level output goes high on a high peak and low on a low trough. The toggle output inverts on every detection of either kind, so two peaks of the same polarity in a row can still be told apart. A select input chooses which of the two drives the primary output. When the envelope span is less than twice the threshold, detection is suppressed, so low-level noise cannot make the outputs chatter.

Top module: `peak_edge_detector`

## Requirements
- R1: While `rst` is high, and after it is released until the first sample, the outputs are: `env_max_o`=0, `env_min_o`=255, `level_o`=0, `toggle_o`=0. Both the high side and the low side are armed.
- R2: A sample above the stored maximum replaces it at the next clock edge. A sample below the stored minimum replaces it at the next clock edge.
- R3: On every 256th sample counted from reset release (samples 255, 511, …), a maximum that is above the sample drops by 1 and a minimum that is below the sample rises by 1. Nothing else decays.
- R4: With span = max−min (0 when max<min) and q = span/4 (rounded down), the levels are: `hi_fire_o`=max−thr, `hi_rearm_o`=hi_fire−q, `lo_fire_o`=min+thr, `lo_rearm_o`=lo_fire+q. Every result is clamped to the range 0..255.
- R5: A sample ≥ `hi_fire_o` while the high side is armed is a high detection. At the next clock edge `level_o` becomes 1, `toggle_o` inverts and the high side disarms. If both sides qualify in the same cycle, the high detection wins.
- R6: A disarmed high side re-arms only after a sample strictly below `hi_rearm_o`. Until then, samples at or above `hi_fire_o` cause no detection.
- R7: The low side mirrors R5 and R6. A sample ≤ `lo_fire_o` while the low side is armed drives `level_o` to 0, inverts `toggle_o` and disarms the low side. The low side re-arms only after a sample strictly above `lo_rearm_o`.
- R8: When span < 2·thr, no detection occurs, and `level_o` and `toggle_o` hold their values.
- R9: `primary_o` equals `level_o` when `sel_i`=0 and equals `toggle_o` when `sel_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 8 | Filtered amplitude sample |
| thr_i | input | 8 | Sensitivity threshold |
| sel_i | input | 1 | Primary output select: 0 level, 1 toggle |
| env_max_o | output | 8 | Tracked envelope maximum |
| env_min_o | output | 8 | Tracked envelope minimum |
| hi_fire_o | output | 8 | High trigger level |
| hi_rearm_o | output | 8 | High re-arm level |
| lo_rearm_o | output | 8 | Low re-arm level |
| lo_fire_o | output | 8 | Low trigger level |
| level_o | output | 1 | Hysteretic peak state |
| toggle_o | output | 1 | Inverts on every detection |
| primary_o | output | 1 | Selected detection output |

## Verification
A corrupted envelope register shows up on the max/min ports one clock after the sample that wrote it. The four level ports show the same error in that same cycle, because they are combinational from the envelope. A lost or stuck arm flag cannot be seen directly. It appears as a missing or extra inversion of `toggle_o` one clock after the next sample that crosses a trigger level, which is why the stimulus revisits each trigger level with and without a prior excursion past the re-arm level. Decay errors appear only at the 256-sample boundary, so the bench reads the envelope just before and just after that boundary.

// File: rtl/ped_pkg.sv
package ped_pkg;

   typedef enum logic [1:0] {
      PED_EV_NONE = 2'd0,
      PED_EV_HIGH = 2'd1,
      PED_EV_LOW  = 2'd2
   } ped_event_e;

   typedef enum logic {
      PED_SEL_LEVEL  = 1'b0,
      PED_SEL_TOGGLE = 1'b1
   } ped_sel_e;

endpackage

// File: rtl/ped_envelope.sv
module ped_envelope #(
   parameter int DW         = 8,
   parameter bit DECAY_EN   = 1'b1,
   parameter int DECAY_LOG2 = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] sample_i,
   output logic [DW-1:0] max_o,
   output logic [DW-1:0] min_o
);

   localparam logic [DW-1:0] TOP_VAL = {DW{1'b1}};
   localparam int            CW      = (DECAY_LOG2 > 0) ? DECAY_LOG2 : 1;

   logic          tick;
   logic [DW-1:0] max_q, min_q;

   if (DW < 2) begin : g_bad_dw
      $error("ped_envelope: DW must be at least 2");
   end

   if (DECAY_EN) begin : g_decay
      logic [CW-1:0] cnt_q;

      if (DECAY_LOG2 < 1) begin : g_bad_decay
         $error("ped_envelope: DECAY_LOG2 must be at least 1 when decay is on");
      end

      always_ff @(posedge clk) begin
         if (rst) cnt_q <= '0;
         else     cnt_q <= cnt_q + 1'b1;
      end
      assign tick = &cnt_q;
   end else begin : g_nodecay
      assign tick = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         max_q <= '0;
         min_q <= TOP_VAL;
      end else begin
         if (sample_i > max_q)
            max_q <= sample_i;
         else if (tick && (max_q > sample_i))
            max_q <= max_q - 1'b1;

         if (sample_i < min_q)
            min_q <= sample_i;
         else if (tick && (min_q < sample_i))
            min_q <= min_q + 1'b1;
      end
   end

   assign max_o = max_q;
   assign min_o = min_q;

   // R2: the maximum never sits below the sample just taken
   a_r2_max_covers: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> max_q >= $past(sample_i));
   // R2: the minimum never sits above the sample just taken
   a_r2_min_covers: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> min_q <= $past(sample_i));
   // R3: a falling maximum only steps by one
   a_r3_max_step: assert property (@(posedge clk) disable iff (rst)
      (max_q < $past(max_q)) |-> (max_q == $past(max_q) - 1'b1));
   // R3: a rising minimum only steps by one
   a_r3_min_step: assert property (@(posedge clk) disable iff (rst)
      (min_q > $past(min_q)) |-> (min_q == $past(min_q) + 1'b1));

endmodule

// File: rtl/ped_levels.sv
module ped_levels #(
   parameter int DW          = 8,
   parameter int REARM_SHIFT = 2
) (
   input  logic [DW-1:0] max_i,
   input  logic [DW-1:0] min_i,
   input  logic [DW-1:0] thr_i,
   output logic [DW-1:0] hi_fire_o,
   output logic [DW-1:0] hi_rearm_o,
   output logic [DW-1:0] lo_rearm_o,
   output logic [DW-1:0] lo_fire_o,
   output logic          en_o
);

   localparam int            EW      = DW + 1;
   localparam logic [DW-1:0] TOP_VAL = {DW{1'b1}};

   if (REARM_SHIFT < 0 || REARM_SHIFT >= DW) begin : g_bad_shift
      $error("ped_levels: REARM_SHIFT must lie in 0..DW-1");
   end

   function automatic logic [DW-1:0] clamp_sub(input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
      return (a >= b) ? (a - b) : '0;
   endfunction

   function automatic logic [DW-1:0] clamp_add(input logic [DW-1:0] a,
                                               input logic [DW-1:0] b);
      logic [EW-1:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[DW] ? TOP_VAL : s[DW-1:0];
   endfunction

   logic [DW-1:0] span, band;
   logic [EW-1:0] need;

   always_comb begin
      span       = (max_i >= min_i) ? (max_i - min_i) : '0;
      band       = span >> REARM_SHIFT;
      need       = {thr_i, 1'b0};
      en_o       = ({1'b0, span} >= need);
      hi_fire_o  = clamp_sub(max_i, thr_i);
      lo_fire_o  = clamp_add(min_i, thr_i);
      hi_rearm_o = clamp_sub(hi_fire_o, band);
      lo_rearm_o = clamp_add(lo_fire_o, band);
   end

   // R4: each re-arm level lies on the inner side of its trigger level
   always_comb begin
      a_r4_band_order: assert ((hi_rearm_o <= hi_fire_o) && (lo_rearm_o >= lo_fire_o));
   end

endmodule

// File: rtl/ped_detector.sv
module ped_detector
   import ped_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] sample_i,
   input  logic [DW-1:0] hi_fire_i,
   input  logic [DW-1:0] hi_rearm_i,
   input  logic [DW-1:0] lo_rearm_i,
   input  logic [DW-1:0] lo_fire_i,
   input  logic          en_i,
   output logic          level_o,
   output logic          toggle_o
);

   ped_event_e ev;
   logic       arm_hi_q, arm_lo_q;
   logic       level_q, toggle_q;

   always_comb begin
      if (en_i && arm_hi_q && (sample_i >= hi_fire_i))
         ev = PED_EV_HIGH;
      else if (en_i && arm_lo_q && (sample_i <= lo_fire_i))
         ev = PED_EV_LOW;
      else
         ev = PED_EV_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q  <= 1'b0;
         toggle_q <= 1'b0;
         arm_hi_q <= 1'b1;
         arm_lo_q <= 1'b1;
      end else begin
         unique case (ev)
            PED_EV_HIGH: begin
               level_q  <= 1'b1;
               toggle_q <= ~toggle_q;
               arm_hi_q <= 1'b0;
            end
            PED_EV_LOW: begin
               level_q  <= 1'b0;
               toggle_q <= ~toggle_q;
               arm_lo_q <= 1'b0;
            end
            default: ;
         endcase
         if ((ev != PED_EV_HIGH) && (sample_i < hi_rearm_i))
            arm_hi_q <= 1'b1;
         if ((ev != PED_EV_LOW) && (sample_i > lo_rearm_i))
            arm_lo_q <= 1'b1;
      end
   end

   assign level_o  = level_q;
   assign toggle_o = toggle_q;

   // R5: level rises only after a sample at or above the high trigger
   a_r5_rise_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(level_q) |-> $past(sample_i >= hi_fire_i));
   // R7: level falls only after a sample at or below the low trigger
   a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(level_q) |-> $past(sample_i <= lo_fire_i));
   // R5: any change of level comes with a toggle inversion
   a_r5_level_toggles: assert property (@(posedge clk) disable iff (rst)
      !$stable(level_q) |-> !$stable(toggle_q));
   // R8: a suppressed cycle leaves both outputs unchanged
   a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> ($stable(toggle_q) && $stable(level_q)));
   // R6: a disarmed high side does not fire on a high sample
   a_r6_no_refire: assert property (@(posedge clk) disable iff (rst)
      (!arm_hi_q && (sample_i >= hi_fire_i) && (sample_i > lo_fire_i)) |=> $stable(toggle_q));

endmodule

// File: rtl/peak_edge_detector.sv
module peak_edge_detector
   import ped_pkg::*;
#(
   parameter int DW          = 8,
   parameter bit DECAY_EN    = 1'b1,
   parameter int DECAY_LOG2  = 8,
   parameter int REARM_SHIFT = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] sample_i,
   input  logic [DW-1:0] thr_i,
   input  logic          sel_i,
   output logic [DW-1:0] env_max_o,
   output logic [DW-1:0] env_min_o,
   output logic [DW-1:0] hi_fire_o,
   output logic [DW-1:0] hi_rearm_o,
   output logic [DW-1:0] lo_rearm_o,
   output logic [DW-1:0] lo_fire_o,
   output logic          level_o,
   output logic          toggle_o,
   output logic          primary_o
);

   logic     en;
   ped_sel_e sel;

   ped_envelope #(.DW(DW), .DECAY_EN(DECAY_EN), .DECAY_LOG2(DECAY_LOG2)) u_env (
      .clk      (clk),
      .rst      (rst),
      .sample_i (sample_i),
      .max_o    (env_max_o),
      .min_o    (env_min_o)
   );

   ped_levels #(.DW(DW), .REARM_SHIFT(REARM_SHIFT)) u_lvl (
      .max_i      (env_max_o),
      .min_i      (env_min_o),
      .thr_i      (thr_i),
      .hi_fire_o  (hi_fire_o),
      .hi_rearm_o (hi_rearm_o),
      .lo_rearm_o (lo_rearm_o),
      .lo_fire_o  (lo_fire_o),
      .en_o       (en)
   );

   ped_detector #(.DW(DW)) u_det (
      .clk        (clk),
      .rst        (rst),
      .sample_i   (sample_i),
      .hi_fire_i  (hi_fire_o),
      .hi_rearm_i (hi_rearm_o),
      .lo_rearm_i (lo_rearm_o),
      .lo_fire_i  (lo_fire_o),
      .en_i       (en),
      .level_o    (level_o),
      .toggle_o   (toggle_o)
   );

   assign sel = ped_sel_e'(sel_i);

   always_comb begin
      unique case (sel)
         PED_SEL_TOGGLE: primary_o = toggle_o;
         default:        primary_o = level_o;
      endcase
   end

   // R1: reset state of the envelope and detection outputs
   a_r1_reset_state: assert property (@(posedge clk)
      $past(rst) |-> (env_max_o == '0 && env_min_o == {DW{1'b1}} && !level_o && !toggle_o));

endmodule

// File: tb/sim_peak_edge_detector.sv
module sim_peak_edge_detector;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 15;

   // {sel, sample, expected level, expected toggle}, threshold 20
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b0, 8'd100, 1'b0, 1'b0},
      {1'b1, 8'd200, 1'b0, 1'b0},
      {1'b1, 8'd100, 1'b0, 1'b1},
      {1'b0, 8'd200, 1'b1, 1'b0},
      {1'b1, 8'd200, 1'b1, 1'b0},
      {1'b0, 8'd160, 1'b1, 1'b0},
      {1'b1, 8'd190, 1'b1, 1'b0},
      {1'b0, 8'd150, 1'b1, 1'b0},
      {1'b1, 8'd190, 1'b1, 1'b1},
      {1'b0, 8'd110, 1'b0, 1'b0},
      {1'b1, 8'd110, 1'b0, 1'b0},
      {1'b0, 8'd130, 1'b0, 1'b0},
      {1'b1, 8'd100, 1'b0, 1'b0},
      {1'b0, 8'd150, 1'b0, 1'b0},
      {1'b1, 8'd115, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sample = '0;
   logic [7:0] thr = 8'd20;
   logic       sel = 1'b0;
   logic [7:0] env_max, env_min, hi_fire, hi_rearm, lo_rearm, lo_fire;
   logic       level, toggle, primary;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   peak_edge_detector u0 (
      .clk        (clk),
      .rst        (rst),
      .sample_i   (sample),
      .thr_i      (thr),
      .sel_i      (sel),
      .env_max_o  (env_max),
      .env_min_o  (env_min),
      .hi_fire_o  (hi_fire),
      .hi_rearm_o (hi_rearm),
      .lo_rearm_o (lo_rearm),
      .lo_fire_o  (lo_fire),
      .level_o    (level),
      .toggle_o   (toggle),
      .primary_o  (primary)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic step(input logic [7:0] s, input logic m);
      @(negedge clk);
      rst    = 1'b0;
      sample = s;
      sel    = m;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_levels(input string req, input int hf, input int hr,
                             input int lr, input int lf);
      chk({req, " hi_fire"},  hi_fire,  hf);
      chk({req, " hi_rearm"}, hi_rearm, hr);
      chk({req, " lo_rearm"}, lo_rearm, lr);
      chk({req, " lo_fire"},  lo_fire,  lf);
   endtask

   initial begin
      do_reset();
      // R1: reset values; R4 clamping at the reset envelope
      chk("R1 max", env_max, 0);
      chk("R1 min", env_min, 255);
      chk("R1 level", level, 0);
      chk("R1 toggle", toggle, 0);
      chk("R9 primary at reset", primary, 0);
      chk_levels("R4 reset clamp", 0, 0, 255, 255);

      // R5 R6 R7 R9: vector walk with threshold 20
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][9:2], VEC[i][10]);
         chk($sformatf("R5/R7 level row %0d", i), level, VEC[i][1]);
         chk($sformatf("R5/R6 toggle row %0d", i), toggle, VEC[i][0]);
         chk($sformatf("R9 primary row %0d", i), primary,
             VEC[i][10] ? VEC[i][0] : VEC[i][1]);
         if (i == 1) begin
            chk("R2 max grows", env_max, 200);
            chk("R2 min shrinks", env_min, 100);
         end
      end
      // R4: levels for max 200, min 100, quarter 25
      chk_levels("R4 thr20", 180, 155, 145, 120);
      thr = 8'd10;
      #1;
      chk_levels("R4 thr10", 190, 165, 135, 110);
      thr = 8'd250;
      #1;
      chk_levels("R4 saturate", 0, 0, 255, 255);

      // R8: span 100 < 2*60 suppresses an otherwise valid high peak
      thr = 8'd60;
      step(8'd200, 1'b0);
      chk("R8 gated level", level, 0);
      chk("R8 gated toggle", toggle, 1);
      // R8 boundary: span 100 == 2*50 enables detection
      thr = 8'd50;
      step(8'd200, 1'b1);
      chk("R8 boundary level", level, 1);
      chk("R8 boundary toggle", toggle, 0);

      // R3: decay on the 256th sample after reset release
      thr = 8'd20;
      do_reset();
      step(8'd200, 1'b0);
      step(8'd50, 1'b0);
      for (int i = 2; i < 255; i++) step(8'd125, 1'b0);
      chk("R3 max before tick", env_max, 200);
      chk("R3 min before tick", env_min, 50);
      step(8'd125, 1'b0);
      chk("R3 max first decay", env_max, 199);
      chk("R3 min first decay", env_min, 51);
      for (int i = 0; i < 255; i++) step(8'd125, 1'b0);
      chk("R3 max held between ticks", env_max, 199);
      step(8'd125, 1'b0);
      chk("R3 max second decay", env_max, 198);
      chk("R3 min second decay", env_min, 52);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule